// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Dispatcher

This block holds a 64-bit interrupt command word that a processor fills through a small word-wide write/read port. Writing the low word launches a message. The block first resolves the message's addressing into a one-hot set of target cores within a small cluster, four cores by default. The addressing can be a destination shorthand, a physical ID match or a logical ID match. In lowest-priority mode the block then narrows that set to the single core that reports the smallest current priority. The result goes out on a message bus with a valid/accept handshake. While the message is in flight, a pending bit reads as 1 in the low word.

A small state machine sequences each send:
- **ST_IDLE** leaves the register open to writes. A low-word write causes the transition *launch*, which goes to ST_RESOLVE.
- **ST_RESOLVE** lasts one cycle. The block computes the target set from the current per-core IDs and priorities and latches it. There are two transitions out of this state:
  - *issue* goes to ST_SEND.
  - *drop* goes back to ST_IDLE. This happens when the delivery mode is reserved or the target set is empty, and no message goes out.
- **ST_SEND** holds the message on the bus. The transition *retire* returns to ST_IDLE on the clock edge where accept is sampled high.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After reset both register words read as zero and msg_valid is 0.
- R2: Only these low-word bits are writable, and all other bits read as zero:
  - vector in bits 7:0
  - delivery mode in bits 10:8
  - destination mode in bit 11
  - level in bit 14
  - trigger in bit 15
  - shorthand in bits 19:18

  Bit 12 reads the pending status. In the high word only bits 31:24 (the destination) are writable. A low write of all ones therefore reads back as 0x000CCFFF, and a high write of all ones reads back as 0xFF000000.
- R3: A low-word write made in ST_IDLE sets the pending bit (bit 12), which reads 1 in the next cycle. msg_valid rises one cycle after that. Pending and msg_valid both clear at the edge where msg_accept is sampled high.
- R4: While a send is pending, writes to either word are ignored.
- R5: Physical addressing (bit 11 = 0, shorthand 00) targets every core whose physical ID equals the destination field.
- R6: Logical addressing (bit 11 = 1, shorthand 00) targets every core whose logical ID has a non-zero bitwise AND with the destination field.
- R7: The shorthand selects the targets directly:
  - 01 targets only core SELF_CORE.
  - 10 targets every core.
  - 11 targets every core except SELF_CORE.
- R8: In delivery mode 001 (lowest priority), exactly one target is sent: the addressed core with the smallest priority value. Ties go to the lowest index.
- R9: While msg_valid is high and accept is low, the targets, vector, type, trigger and level stay unchanged. The type, trigger and level equal the register fields.
- R10: For delivery mode 100 (NMI) the vector on the bus is zero. The other modes pass the vector field unchanged.
- R11: Reserved delivery modes 011 and 111, or an empty target set, produce no msg_valid, and the pending bit clears one cycle after it was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write word select: 0 low, 1 high |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read word select: 0 low, 1 high |
| rd_data | output | 32 | Read data for the selected word |
| core_phys_id | input | NCORE*8 | Physical ID per core, core i at bits 8i+7:8i |
| core_log_id | input | NCORE*8 | Logical ID per core |
| core_prio | input | NCORE*PRIO_W | Current priority per core, lower value wins |
| msg_valid | output | 1 | Message present on the bus |
| msg_accept | input | 1 | Bus takes the message |
| msg_targets | output | NCORE | One-hot or multi-hot target mask |
| msg_vector | output | 8 | Interrupt vector |
| msg_type | output | 3 | Delivery mode |
| msg_trigger | output | 1 | Trigger mode, 1 level |
| msg_level | output | 1 | Level, 1 assert |

## Verification
Each addressing path is driven by a destination chosen so that it separates that path from the others:
- A physical destination that matches exactly one ID.
- A logical mask that hits two cores.
- Each of the three shorthands, which distinguish including self from excluding self.

Lowest-priority sends use three priority patterns:
- A tie, which shows the lowest index wins.
- A minimum at a higher index.
- A minimum on the excluded self core, which must be skipped.

Accept delays of zero and several cycles show that the message holds steady on the bus. Writes are made during a pending send to show they are ignored. Reserved modes and an address that matches no core show that the send is dropped.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_RSV7   = 3'd7
    } dmode_t;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } short_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_SEND    = 2'd2
    } st_t;
endpackage

// File: rtl/ipi_dest_decode.sv
module ipi_dest_decode
    import ipi_pkg::*;
#(
    parameter int NCORE     = 4,
    parameter int ID_W      = 8,
    parameter int SELF_CORE = 0
) (
    input  short_t               shorthand,
    input  logic                 logical,
    input  logic [ID_W-1:0]      dest,
    input  logic [NCORE*ID_W-1:0] phys_ids,
    input  logic [NCORE*ID_W-1:0] log_ids,
    output logic [NCORE-1:0]     hits
);
    for (genvar i = 0; i < NCORE; i++) begin : g_core
        logic field_hit;
        assign field_hit = logical
            ? ((dest & log_ids[i*ID_W +: ID_W]) != '0)
            : (dest == phys_ids[i*ID_W +: ID_W]);

        always_comb begin
            unique case (shorthand)
                SH_FIELD:  hits[i] = field_hit;
                SH_SELF:   hits[i] = (i == SELF_CORE);
                SH_ALL:    hits[i] = 1'b1;
                SH_OTHERS: hits[i] = (i != SELF_CORE);
                default:   hits[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ipi_lowprio_pick.sv
module ipi_lowprio_pick #(
    parameter int NCORE  = 4,
    parameter int PRIO_W = 4
) (
    input  logic [NCORE-1:0]        cand,
    input  logic [NCORE*PRIO_W-1:0] prio,
    output logic [NCORE-1:0]        pick
);
    logic              found;
    logic [PRIO_W-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        pick  = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (cand[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best)) begin
                found   = 1'b1;
                best    = prio[i*PRIO_W +: PRIO_W];
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
    import ipi_pkg::*;
#(
    parameter int NCORE     = 4,
    parameter int PRIO_W    = 4,
    parameter int SELF_CORE = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_addr,
    input  logic [31:0]             wr_data,
    input  logic                    rd_addr,
    output logic [31:0]             rd_data,
    input  logic [NCORE*8-1:0]      core_phys_id,
    input  logic [NCORE*8-1:0]      core_log_id,
    input  logic [NCORE*PRIO_W-1:0] core_prio,
    output logic                    msg_valid,
    input  logic                    msg_accept,
    output logic [NCORE-1:0]        msg_targets,
    output logic [7:0]              msg_vector,
    output logic [2:0]              msg_type,
    output logic                    msg_trigger,
    output logic                    msg_level
);
    localparam int DEST_W = 8;

    st_t               state_q, state_d;
    logic [7:0]        vec_q;
    dmode_t            mode_q;
    logic              logical_q;
    logic              level_q;
    logic              trig_q;
    short_t            short_q;
    logic [DEST_W-1:0] dest_q;
    logic [NCORE-1:0]  mask_q;

    logic [NCORE-1:0]  decoded, picked, resolved;
    logic              reserved_mode, drop, lo_wr, hi_wr, pending;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[23:20], wr_data[17:16], wr_data[13:12]};

    assign lo_wr = wr_en && !wr_addr && (state_q == ST_IDLE);
    assign hi_wr = wr_en &&  wr_addr && (state_q == ST_IDLE);

    ipi_dest_decode #(
        .NCORE(NCORE), .ID_W(DEST_W), .SELF_CORE(SELF_CORE)
    ) u_decode (
        .shorthand(short_q),
        .logical  (logical_q),
        .dest     (dest_q),
        .phys_ids (core_phys_id),
        .log_ids  (core_log_id),
        .hits     (decoded)
    );

    ipi_lowprio_pick #(
        .NCORE(NCORE), .PRIO_W(PRIO_W)
    ) u_pick (
        .cand(decoded),
        .prio(core_prio),
        .pick(picked)
    );

    assign resolved      = (mode_q == DM_LOWPRI) ? picked : decoded;
    assign reserved_mode = (mode_q == DM_RSV3) || (mode_q == DM_RSV7);
    assign drop          = reserved_mode || (resolved == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (lo_wr) state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = drop ? ST_IDLE : ST_SEND;
            ST_SEND:    if (msg_accept) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command word and latched target set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q     <= '0;
            mode_q    <= DM_FIXED;
            logical_q <= 1'b0;
            level_q   <= 1'b0;
            trig_q    <= 1'b0;
            short_q   <= SH_FIELD;
            dest_q    <= '0;
            mask_q    <= '0;
        end else begin
            if (lo_wr) begin
                vec_q     <= wr_data[7:0];
                mode_q    <= dmode_t'(wr_data[10:8]);
                logical_q <= wr_data[11];
                level_q   <= wr_data[14];
                trig_q    <= wr_data[15];
                short_q   <= short_t'(wr_data[19:18]);
            end
            if (hi_wr) dest_q <= wr_data[31:24];
            if (state_q == ST_RESOLVE) mask_q <= resolved;
        end
    end

    // outputs
    assign pending = (state_q != ST_IDLE);

    always_comb begin
        msg_valid   = (state_q == ST_SEND);
        msg_targets = msg_valid ? mask_q : '0;
        msg_vector  = (msg_valid && mode_q != DM_NMI) ? vec_q : 8'h00;
        msg_type    = msg_valid ? mode_q : 3'd0;
        msg_trigger = msg_valid && trig_q;
        msg_level   = msg_valid && level_q;
        if (rd_addr)
            rd_data = {dest_q, 24'h0};
        else
            rd_data = {12'h0, short_q, 2'b00, trig_q, level_q, 1'b0,
                       pending, logical_q, mode_q, vec_q};
    end
endmodule

// File: rtl/ipi_cmd_dispatch_chk.sv
module ipi_cmd_dispatch_chk #(
    parameter int NCORE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_accept,
    input logic [NCORE-1:0] msg_targets,
    input logic [7:0]       msg_vector,
    input logic [2:0]       msg_type
);
    // R9
    hold_until_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_accept) |=> (msg_valid && $stable(msg_targets)
                                        && $stable(msg_vector) && $stable(msg_type)));

    // R3
    retire_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_accept) |=> !msg_valid);

    // R8
    lowprio_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == 3'd1) |-> ($countones(msg_targets) == 1));

    // R10
    nmi_vector_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == 3'd4) |-> (msg_vector == 8'h00));

    // R11
    no_reserved_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_type != 3'd3 && msg_type != 3'd7 && msg_targets != '0));
endmodule

bind ipi_cmd_dispatch ipi_cmd_dispatch_chk #(.NCORE(NCORE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_accept (msg_accept),
    .msg_targets(msg_targets),
    .msg_vector (msg_vector),
    .msg_type   (msg_type)
);

// File: tb/ipi_cmd_dispatch_test.sv
module ipi_cmd_dispatch_test;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] phys_ids = 32'h23222120;
    logic [31:0] log_ids  = 32'h08040201;
    logic [15:0] prio = 16'h0000;
    logic        msg_valid, msg_accept = 1'b0, msg_trigger, msg_level;
    logic [NC-1:0] msg_targets;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_type;

    int checks = 0;
    int errors = 0;

    ipi_cmd_dispatch #(.NCORE(NC), .PRIO_W(4), .SELF_CORE(0)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .core_phys_id(phys_ids), .core_log_id(log_ids), .core_prio(prio),
        .msg_valid(msg_valid), .msg_accept(msg_accept),
        .msg_targets(msg_targets), .msg_vector(msg_vector),
        .msg_type(msg_type), .msg_trigger(msg_trigger), .msg_level(msg_level)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_lo = '0, m_hi = '0;
    logic [3:0]  m_mask = '0;
    int          mst = 0;

    function automatic logic [3:0] m_targets(logic [31:0] lo, logic [31:0] hi,
                                             logic [15:0] pr);
        logic [3:0] set = '0;
        logic [7:0] dest = hi[31:24];
        int best = -1;
        for (int i = 0; i < NC; i++) begin
            case (lo[19:18])
                2'd0: set[i] = lo[11] ? ((dest & log_ids[8*i +: 8]) != 0)
                                      : (dest == phys_ids[8*i +: 8]);
                2'd1: set[i] = (i == 0);
                2'd2: set[i] = 1'b1;
                default: set[i] = (i != 0);
            endcase
        end
        if (lo[10:8] == 3'd1) begin
            for (int i = 0; i < NC; i++)
                if (set[i] && (best < 0 || pr[4*i +: 4] < pr[4*best +: 4])) best = i;
            set = (best < 0) ? 4'd0 : 4'(1 << best);
        end
        return set;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = '0; m_hi = '0; m_mask = '0; mst = 0;
        end else begin
            case (mst)
                0: if (wr_en && !wr_addr) begin m_lo = wr_data & 32'h000CCFFF; mst = 1; end
                   else if (wr_en && wr_addr) m_hi = wr_data & 32'hFF000000;
                1: begin
                    m_mask = m_targets(m_lo, m_hi, prio);
                    if (m_lo[10:8] == 3'd3 || m_lo[10:8] == 3'd7 || m_mask == 0) mst = 0;
                    else mst = 2;
                end
                default: if (msg_accept) mst = 0;
            endcase
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic ev;
            logic [31:0] erd;
            ev  = (mst == 2);
            erd = rd_addr ? m_hi : (m_lo | ((mst != 0) ? 32'h1000 : 32'h0));
            chk(msg_valid == ev, "R3 valid", 32'(msg_valid), 32'(ev));
            chk(msg_targets == (ev ? m_mask : 4'd0), "R9 targets",
                32'(msg_targets), 32'(ev ? m_mask : 4'd0));
            chk(msg_vector == ((ev && m_lo[10:8] != 3'd4) ? m_lo[7:0] : 8'h00), "R10 vector",
                32'(msg_vector), 32'((ev && m_lo[10:8] != 3'd4) ? m_lo[7:0] : 8'h00));
            chk({msg_type, msg_trigger, msg_level} ==
                (ev ? {m_lo[10:8], m_lo[15], m_lo[14]} : 5'd0), "R9 type/trig/level",
                32'({msg_type, msg_trigger, msg_level}),
                32'(ev ? {m_lo[10:8], m_lo[15], m_lo[14]} : 5'd0));
            chk(rd_data == erd, "R2 readback", rd_data, erd);
        end
    end

    task automatic write_word(input logic a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    logic [3:0] s_tgt;
    logic [7:0] s_vec;
    bit         s_saw;

    task automatic send(input logic [31:0] lo, input int dly, input bit poke);
        int cnt = 0;
        s_saw = 0; s_tgt = '0; s_vec = '0;
        @(negedge clk); wr_en = 1'b1; wr_addr = 1'b0; wr_data = lo;
        @(negedge clk); wr_en = 1'b0; rd_addr = 1'b0;
        #1 chk(rd_data[12] == 1'b1, "R3 pending set", 32'(rd_data[12]), 1);
        for (int k = 0; k < 40; k++) begin
            if (msg_valid) begin
                if (!s_saw) begin s_saw = 1; s_tgt = msg_targets; s_vec = msg_vector; end
                if (poke && cnt == 0) begin wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h00000555; end
                if (poke && cnt == 1) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'hAB000000; end
                if (cnt == dly) msg_accept = 1'b1;
                cnt++;
            end else if (mst == 0) begin
                break;
            end
            @(negedge clk); msg_accept = 1'b0; wr_en = 1'b0;
        end
        #1 chk(rd_data[12] == 1'b0, "R3 pending clear", 32'(rd_data[12]), 0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_addr = 1'b0; #1 chk(rd_data == 0, "R1 low word", rd_data, 0);
        chk(msg_valid == 0, "R1 valid", 32'(msg_valid), 0);
        rd_addr = 1'b1; #1 chk(rd_data == 0, "R1 high word", rd_data, 0);

        write_word(1'b1, 32'hFFFFFFFF);
        rd_addr = 1'b1; #1 chk(rd_data == 32'hFF000000, "R2 high mask", rd_data, 32'hFF000000);
        rd_addr = 1'b0;

        // R5 physical match on core 2
        write_word(1'b1, 32'h22000000);
        send(32'h00000041, 0, 0);
        chk(s_saw && s_tgt == 4'b0100, "R5 physical", 32'(s_tgt), 32'h4);
        chk(s_vec == 8'h41, "R10 fixed vector", 32'(s_vec), 32'h41);

        // R6 logical mask hits cores 1 and 2, level trigger asserted, slow accept
        write_word(1'b1, 32'h06000000);
        send(32'h0000C833, 3, 0);
        chk(s_tgt == 4'b0110, "R6 logical", 32'(s_tgt), 32'h6);

        // R8 tie between cores 1 and 2
        prio = 16'h5113;
        write_word(1'b1, 32'h0F000000);
        send(32'h00000950, 2, 0);
        chk(s_tgt == 4'b0010, "R8 tie", 32'(s_tgt), 32'h2);

        // R8 minimum at core 3
        prio = 16'h1567;
        send(32'h00000951, 0, 0);
        chk(s_tgt == 4'b1000, "R8 min high index", 32'(s_tgt), 32'h8);

        // R8 with R7: self core has lowest priority but is excluded
        prio = 16'h4920;
        send(32'h000C0152, 1, 0);
        chk(s_tgt == 4'b0010, "R8 excl self", 32'(s_tgt), 32'h2);

        // R7 shorthands
        send(32'h00040060, 0, 0);
        chk(s_tgt == 4'b0001, "R7 self", 32'(s_tgt), 32'h1);
        send(32'h00080061, 1, 0);
        chk(s_tgt == 4'b1111, "R7 all", 32'(s_tgt), 32'hF);
        send(32'h000C0062, 0, 0);
        chk(s_tgt == 4'b1110, "R7 others", 32'(s_tgt), 32'hE);

        // R10 NMI vector forced to zero
        write_word(1'b1, 32'h21000000);
        send(32'h00000477, 2, 0);
        chk(s_tgt == 4'b0010 && s_vec == 8'h00, "R10 nmi", 32'({s_tgt, s_vec}), 32'h200);

        // R4 writes during a pending send
        send(32'h00000288, 4, 1);
        rd_addr = 1'b0; #1 chk(rd_data == 32'h00000288, "R4 low kept", rd_data, 32'h288);
        rd_addr = 1'b1; #1 chk(rd_data == 32'h21000000, "R4 high kept", rd_data, 32'h21000000);
        rd_addr = 1'b0;

        // R11 reserved mode and empty target set
        send(32'h00000399, 0, 0);
        chk(!s_saw, "R11 reserved 3", 32'(s_saw), 0);
        write_word(1'b1, 32'h55000000);
        send(32'h00000012, 0, 0);
        chk(!s_saw, "R11 empty set", 32'(s_saw), 0);
        send(32'hFFFFFFFF, 0, 0);
        chk(!s_saw, "R11 reserved 7", 32'(s_saw), 0);
        #1 chk(rd_data == 32'h000CCFFF, "R2 low mask", rd_data, 32'h000CCFFF);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule